// File: doc/BRIEF.md
# Indexed Register Access Port

This block sits behind a narrow host bus. It lets the host reach a register space of 256 byte addresses through a single index register. A select line tells the block what a host write carries. With the select line low, the write loads the index. With the select line high, the write or read goes to the register that the index points at. After each data access the index moves forward on its own, so a run of registers can be filled or dumped without reloading the index.

Two addresses are streaming ports into tables, and each table has its own pointer:
- a 32-entry coefficient table, whose pointer stops at the end of the table;
- a 256-entry gamma table, whose pointer wraps around.

The block also holds:
- an interrupt status byte that hardware sets and the host clears by writing zeros;
- a discard counter that makes the port ignore a programmed number of following accesses;
- a fixed revision byte;
- a small store of general-purpose registers that stands in for the rest of the device's registers.

Read data appears one cycle after the read strobe, together with `rd_valid`.

Top module: `idx_reg_port`

## Requirements
- R1: A write with `acc_sel` low loads the index with `acc_wdata[7:0]`. The upper bits are ignored.
- R2: A write with `acc_sel` high updates the register at the index. The index then advances by 2, modulo 256. The exception is an index of 0x5A, 0x90 or 0xB8, where the index is left unchanged.
- R3: A read with `acc_sel` high returns the indexed register on `rd_data` in the cycle after the strobe, with `rd_valid` high, and advances the index by 1. A read with `acc_sel` low returns the index value, zero-extended, and leaves the index unchanged.
- R4: Writing N to address 0xFE loads the discard counter. While the counter is non-zero, each access decrements it and has no other effect. A discarded read returns 0 with `rd_valid` high.
- R5: Address 0x58 is the coefficient pointer. Writes load `acc_wdata[4:0]`, and reads return the pointer, which can hold values 0 to 32. Each data access at 0x5A reads or writes entry[pointer] (the low 8 bits) and then increments the pointer, but only while the pointer is below 32. At 32, writes are ignored, reads return 0, and the pointer holds.
- R6: Address 0xB6 is the 8-bit gamma pointer, and it is readable. Each data access at 0xB8 reads or writes entry[pointer] (the low 8 bits) of a 256-entry table and then increments the pointer, wrapping from 255 to 0.
- R7: Address 0xF6 is the 8-bit interrupt status. Every cycle, the bits of `irq_set` are ORed into it. A write ANDs `acc_wdata[7:0]` into it; if a bit is set in the same cycle it is written to zero, the set wins. `irq` is the OR of all status bits.
- R8: Reading address 0x00 returns 0xA5.
- R9: The 16 general registers sit at the even addresses 0x20 to 0x3E and hold the full 16 bits. Reads of any address without a function return 0, and writes to such addresses change nothing.
- R10: After reset, the following are all 0: the index, both pointers, the status, the discard counter, the general registers, `irq` and `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = index access, 1 = data access |
| acc_wdata | input | 16 | Write data |
| irq_set | input | 8 | Status bits to set this cycle |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 16 | Read data |
| irq | output | 1 | Any status bit set |

## Verification
The advance rule is tested by writing to and reading from every one of the 256 addresses and reading the index back after each access. This shows the +2, +1 and hold cases apart at every address, including the streaming exceptions and the wrap at 0xFF. The same read sweep checks that only the mapped addresses return anything other than zero.

The tables are filled and dumped in full with arithmetic patterns:
- the gamma fill starts mid-table, so the wrap is tested;
- the coefficient fill runs one entry past the end, so the cap and the ignored overflow write are tested.

Status set/clear conflicts and a discarded read, taken at an address that would otherwise return a non-zero value, separate an ignored access from a real one.

// File: rtl/idx_reg_port.sv
module idx_reg_port #(
  parameter int DW       = 16,
  parameter int SW       = 8,
  parameter int TW       = 8,
  parameter int GEN_N    = 16,
  parameter int GEN_BASE = 32,
  parameter int SKIPW    = 8,
  parameter int FDEPTH   = 32,
  parameter int GDEPTH   = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_wr,
  input  logic          acc_sel,
  input  logic [DW-1:0] acc_wdata,
  input  logic [SW-1:0] irq_set,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int FAW = $clog2(FDEPTH);
  localparam int GAW = $clog2(GDEPTH);
  localparam int GKW = $clog2(GEN_N);
  localparam logic [7:0] A_REV  = 8'h00;
  localparam logic [7:0] A_FIDX = 8'h58;
  localparam logic [7:0] A_FDAT = 8'h5A;
  localparam logic [7:0] A_MDAT = 8'h90;
  localparam logic [7:0] A_GIDX = 8'hB6;
  localparam logic [7:0] A_GDAT = 8'hB8;
  localparam logic [7:0] A_STAT = 8'hF6;
  localparam logic [7:0] A_SKIP = 8'hFE;
  localparam logic [7:0] REV_CODE = 8'hA5;

  logic [7:0]     idx;
  logic [FAW:0]   fptr;
  logic [GAW-1:0] gptr;
  logic [SW-1:0]  stat;
  logic [SKIPW-1:0] skip;
  logic [DW-1:0]  gen [GEN_N];
  logic [TW-1:0]  ftab [FDEPTH];
  logic [TW-1:0]  gtab [GDEPTH];
  logic [TW-1:0]  frd, grd;
  logic [DW-1:0]  rreg, rmux;
  logic [1:0]     rsrc;

  wire drop = acc_valid && (skip != '0);
  wire live = acc_valid && (skip == '0);
  wire dwr  = live && acc_wr && acc_sel;
  wire drd  = live && !acc_wr && acc_sel;
  wire stream = (idx == A_FDAT) || (idx == A_MDAT) || (idx == A_GDAT);

  wire [7:0] goff = idx - GEN_BASE[7:0];
  wire gen_hit = !goff[0] && (goff < 8'(2 * GEN_N));
  wire [GKW-1:0] gk = goff[GKW:1];

  wire f_in = !fptr[FAW];
  wire fwe = dwr && (idx == A_FDAT) && f_in;
  wire fre = drd && (idx == A_FDAT) && f_in;
  wire gwe = dwr && (idx == A_GDAT);
  wire gre = drd && (idx == A_GDAT);
  wire [SW-1:0] smask = (dwr && idx == A_STAT) ? acc_wdata[SW-1:0] : '1;

  always_comb begin
    rmux = '0;
    if (gen_hit) rmux = gen[gk];
    case (idx)
      A_REV:  rmux = DW'(REV_CODE);
      A_FIDX: rmux = DW'(fptr);
      A_GIDX: rmux = DW'(gptr);
      A_STAT: rmux = DW'(stat);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; fptr <= '0; gptr <= '0; stat <= '0; skip <= '0;
      rd_valid <= 1'b0; rreg <= '0; rsrc <= 2'd0;
      for (int k = 0; k < GEN_N; k++) gen[k] <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_wr;
      stat <= (stat & smask) | irq_set;
      if (drop) begin
        skip <= skip - 1'b1;
        rreg <= '0;
        rsrc <= 2'd0;
      end else if (live) begin
        if (!acc_sel) begin
          if (acc_wr) idx <= acc_wdata[7:0];
          else begin rreg <= DW'(idx); rsrc <= 2'd0; end
        end else if (acc_wr) begin
          if (!stream) idx <= idx + 8'd2;
          if (gen_hit) gen[gk] <= acc_wdata;
          case (idx)
            A_FIDX: fptr <= {1'b0, acc_wdata[FAW-1:0]};
            A_GIDX: gptr <= acc_wdata[GAW-1:0];
            A_SKIP: skip <= acc_wdata[SKIPW-1:0];
            A_FDAT: if (f_in) fptr <= fptr + 1'b1;
            A_GDAT: gptr <= gptr + 1'b1;
            default: ;
          endcase
        end else begin
          idx <= idx + 8'd1;
          case (idx)
            A_FDAT: begin
              if (f_in) begin rsrc <= 2'd1; fptr <= fptr + 1'b1; end
              else begin rsrc <= 2'd0; rreg <= '0; end
            end
            A_GDAT: begin rsrc <= 2'd2; gptr <= gptr + 1'b1; end
            default: begin rsrc <= 2'd0; rreg <= rmux; end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fwe) ftab[fptr[FAW-1:0]] <= acc_wdata[TW-1:0];
    if (fre) frd <= ftab[fptr[FAW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (gwe) gtab[gptr] <= acc_wdata[TW-1:0];
    if (gre) grd <= gtab[gptr];
  end

  assign rd_data = (rsrc == 2'd1) ? {{(DW-TW){1'b0}}, frd} :
                   (rsrc == 2'd2) ? {{(DW-TW){1'b0}}, grd} : rreg;
  assign irq = |stat;

  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    live && acc_wr && !acc_sel |=> idx == $past(acc_wdata[7:0])); // R1
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && !stream |=> idx == $past(idx) + 8'd2); // R2
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && stream |=> $stable(idx)); // R2
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    drd |=> idx == $past(idx) + 8'd1); // R3
  AST_DROP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> skip == $past(skip) - 1'b1 && $stable(idx)); // R4
  AST_DROP_RD: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !acc_wr |=> rd_valid && rd_data == '0); // R4
  AST_FPTR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    fptr <= (FAW+1)'(FDEPTH)); // R5
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && idx == A_FDAT && !f_in |=> $stable(fptr)); // R5
  AST_STAT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~$past(stat) & ~$past(irq_set)) == '0); // R7
endmodule

// File: tb/sim_idx_reg_port.sv
`timescale 1ns/1ps
module sim_idx_reg_port;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_wr = 0, acc_sel = 0;
  logic [15:0] acc_wdata = 0;
  logic [7:0] irq_set = 0;
  logic rd_valid, irq;
  logic [15:0] rd_data;
  int nvec = 0, nerr = 0;

  idx_reg_port u0 (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .irq_set(irq_set),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic w, input logic s, input logic [15:0] d);
    @(negedge clk); acc_valid = 1; acc_wr = w; acc_sel = s; acc_wdata = d;
    @(negedge clk); acc_valid = 0; acc_wr = 0; acc_sel = 0; acc_wdata = 0;
  endtask

  task automatic setidx(input logic [7:0] a); acc(1, 0, {8'h00, a}); endtask
  task automatic wr(input logic [7:0] a, input logic [15:0] d); setidx(a); acc(1, 1, d); endtask
  task automatic rdd(output logic [15:0] v); acc(0, 1, 0); v = rd_data; endtask
  task automatic rd(input logic [7:0] a, output logic [15:0] v); setidx(a); rdd(v); endtask
  task automatic getidx(output logic [15:0] v); acc(0, 0, 0); v = rd_data; endtask

  function automatic logic [7:0] gpat(input int i); return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] fpat(input int i); return 8'((i * 53 + 11) & 255); endfunction
  function automatic logic [15:0] gvpat(input int k); return 16'(k * 16'h0911 + 16'h00C3); endfunction

  initial begin
    #800000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R10 irq", {15'd0, irq}, 16'd0);
    chk("R10 rd_valid", {15'd0, rd_valid}, 16'd0);
    getidx(v); chk("R10 index", v, 16'h0000);
    chk("R3 rd_valid", {15'd0, rd_valid}, 16'd1);
    rd(8'h58, v); chk("R10 fptr", v, 16'h0000);
    rd(8'hB6, v); chk("R10 gptr", v, 16'h0000);
    rd(8'hF6, v); chk("R10 status", v, 16'h0000);
    rd(8'h20, v); chk("R10 gen", v, 16'h0000);

    rd(8'h00, v); chk("R8 revision", v, 16'h00A5);
    getidx(v); chk("R3 index after read", v, 16'h0001);
    acc(1, 0, 16'h5A37); getidx(v); chk("R1 index low byte", v, 16'h0037);

    for (int a = 0; a < 256; a++) begin
      logic [7:0] e;
      wr(8'(a), 16'h0000);
      e = (a == 8'h5A || a == 8'h90 || a == 8'hB8) ? 8'(a) : 8'(a + 2);
      getidx(v); chk("R2 write advance", v, {8'h00, e});
    end
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), v);
      if (a != 8'h58 && a != 8'h5A && a != 8'hB6 && a != 8'hB8)
        chk("R9 sweep read", v, (a == 0) ? 16'h00A5 : 16'h0000);
      getidx(v); chk("R3 read advance", v, {8'h00, 8'(a + 1)});
    end

    setidx(8'h20);
    for (int k = 0; k < 16; k++) acc(1, 1, gvpat(k));
    getidx(v); chk("R2 burst index", v, 16'h0040);
    wr(8'h21, 16'hFFFF);
    wr(8'h40, 16'hFFFF);
    rd(8'h21, v); chk("R9 odd addr", v, 16'h0000);
    rd(8'h40, v); chk("R9 past store", v, 16'h0000);
    for (int k = 0; k < 16; k++) begin
      rd(8'(8'h20 + 2 * k), v); chk("R9 gen readback", v, gvpat(k));
    end

    wr(8'h58, 16'hFFE0); rd(8'h58, v); chk("R5 index mask 0", v, 16'h0000);
    wr(8'h58, 16'h003F); rd(8'h58, v); chk("R5 index mask 1f", v, 16'h001F);
    setidx(8'h58); acc(1, 1, 16'h0000);
    for (int i = 0; i < 32; i++) acc(1, 1, {8'hC0, fpat(i)});
    getidx(v); chk("R2 stream hold", v, 16'h005A);
    rd(8'h58, v); chk("R5 pointer full", v, 16'h0020);
    wr(8'h5A, 16'h0077);
    rd(8'h58, v); chk("R5 pointer capped", v, 16'h0020);
    rd(8'h5A, v); chk("R5 read at end", v, 16'h0000);
    rd(8'h58, v); chk("R5 pointer after end read", v, 16'h0020);
    wr(8'h58, 16'h0000);
    for (int i = 0; i < 32; i++) begin
      rd(8'h5A, v); chk("R5 table readback", v, {8'h00, fpat(i)});
    end

    wr(8'hB6, 16'h0010);
    setidx(8'hB8);
    for (int i = 0; i < 256; i++) acc(1, 1, {8'h3C, gpat(i)});
    rd(8'hB6, v); chk("R6 pointer wrap", v, 16'h0010);
    wr(8'hB6, 16'h0000);
    for (int i = 0; i < 256; i++) begin
      rd(8'hB8, v); chk("R6 table readback", v, {8'h00, gpat((i - 16) & 255)});
    end
    rd(8'hB6, v); chk("R6 pointer after full read", v, 16'h0000);

    @(negedge clk); irq_set = 8'h5C; @(negedge clk); irq_set = 8'h00;
    chk("R7 irq set", {15'd0, irq}, 16'd1);
    rd(8'hF6, v); chk("R7 status set", v, 16'h005C);
    wr(8'hF6, 16'hFFF0); rd(8'hF6, v); chk("R7 and clear", v, 16'h0050);
    wr(8'hF6, 16'h0000); rd(8'hF6, v); chk("R7 clear all", v, 16'h0000);
    chk("R7 irq low", {15'd0, irq}, 16'd0);
    setidx(8'hF6);
    @(negedge clk); irq_set = 8'h01; acc_valid = 1; acc_wr = 1; acc_sel = 1; acc_wdata = 16'h0000;
    @(negedge clk); irq_set = 8'h00; acc_valid = 0; acc_wr = 0; acc_sel = 0;
    rd(8'hF6, v); chk("R7 set wins", v, 16'h0001);

    wr(8'hFE, 16'h0002);
    rdd(v); chk("R4 dropped read", v, 16'h0000);
    chk("R4 dropped rd_valid", {15'd0, rd_valid}, 16'd1);
    acc(1, 0, 16'h0020);
    getidx(v); chk("R4 index unchanged", v, 16'h0000);
    rdd(v); chk("R4 live again", v, 16'h00A5);
    wr(8'hFE, 16'h0001);
    acc(1, 1, 16'hDEAD);
    rd(8'h20, v); chk("R4 dropped write", v, gvpat(0));

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule